// File: doc/BRIEF.md
# Single-Wire Bus Master Controller

This block is the master of a single-wire, open-drain bus. It turns simple host commands into timed line activity. A command can be a bus reset with a presence check, a write time slot for one bit, a read time slot for one bit, or a strong-pullup hold of fixed length. The hold follows a temperature-convert command, and its length depends on the conversion resolution. The block either pulls the line low or releases it; it never drives the line high. All of its timing is given in microseconds and is converted to clock cycles from the clock-frequency parameter.

The host places a command while `busy` is low and raises `cmd_valid` for at least one clock. The block then runs the command to the end. On the clock where `busy` falls, `done` pulses for one cycle. After a reset command, `presence` holds the result of that reset. After a read command, `rd_bit` holds the bit that was sampled. The bus input `line_in` is assumed to be already synchronised to `clk`.

Top module: `ow_master`

## Requirements
- R1: After a synchronous reset (`rst_n` low), `busy`, `done`, `ow_drive_low`, `spu_en`, `presence` and `rd_bit` are all 0.
- R2: A reset command (`cmd_op`=2'b00) drives the line low for exactly T_RSTL_US µs. It then releases the line for exactly T_RSTH_US µs, and `busy` is high for that whole time. No low period of the line ever reaches 960 µs.
- R3: During the release window of a reset, `presence` takes the inverted line level sampled T_PDS_US µs after the release: 1 if the line is low there, 0 if it is high. `presence` reads 0 from the start of each reset command.
- R4: A write command (`cmd_op`=2'b01) with `cmd_bit`=0 drives the line low for exactly T_LOW0_US µs, measured from the start of a slot that lasts T_SLOT_US µs.
- R5: A write command with `cmd_bit`=1 drives the line low for exactly T_LOW1_US µs and then releases it for the rest of the slot.
- R6: A read command (`cmd_op`=2'b10) drives the line low for T_RDLOW_US µs. `rd_bit` then takes the line level sampled T_RDS_US µs after the slot start.
- R7: Each slot is followed by a recovery of T_REC_US µs with the line released. `busy` covers exactly T_SLOT_US + T_REC_US µs.
- R8: A pullup command (`cmd_op`=2'b11) raises `spu_en` on the clock after acceptance, which is within 10 µs. The line stays released while `spu_en` is high. The hold lasts SPU_BASE_US·2^`cmd_res` µs, with `cmd_res` 0..3 meaning 9..12-bit resolution.
- R9: While `busy` is high, `cmd_valid` and the command fields are ignored. The running command's line timing is unchanged, and no second command starts afterwards.
- R10: Every command ends with exactly one `done` pulse of one cycle, on the first cycle in which `busy` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at CLK_HZ |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command request, taken while busy is low |
| cmd_op | input | 2 | 00 reset, 01 write, 10 read, 11 strong pullup |
| cmd_bit | input | 1 | Bit value for a write command |
| cmd_res | input | 2 | Resolution for the pullup hold, 0..3 = 9..12 bit |
| line_in | input | 1 | Synchronised bus level |
| busy | output | 1 | A command is in progress |
| done | output | 1 | One-cycle pulse when a command ends |
| presence | output | 1 | Presence result of the last reset |
| rd_bit | output | 1 | Bit from the last read slot |
| ow_drive_low | output | 1 | 1 pulls the line low, 0 releases it |
| spu_en | output | 1 | Strong pullup enable |

## Verification
The bench builds the block with CLK_HZ = 2 MHz, so one microsecond is two cycles. This keeps the half-millisecond reset windows down to about a thousand cycles each. SPU_BASE_US is cut from 93750 to 40, so all four resolution holds, the largest being eight times the base, fit into a short run, and the doubling per resolution step can still be counted cycle by cycle. A behavioural slave on the bench answers resets and read slots. This exercises both presence outcomes and both read values against the exact sampling instants.

// File: rtl/ow_pkg.sv
// Shared encodings for the single-wire bus master.
// Assumes: command codes are fixed by the host-side register layout.
package ow_pkg;
    typedef enum logic [1:0] {
        OP_RESET  = 2'b00,
        OP_WRITE  = 2'b01,
        OP_READ   = 2'b10,
        OP_PULLUP = 2'b11
    } ow_op_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RST_LOW,
        ST_RST_HIGH,
        ST_SLOT,
        ST_RECOVER,
        ST_PULLUP
    } ow_state_e;
endpackage

// File: rtl/ow_us_timer.sv
// Microsecond phase timer: counts whole microseconds since the last clear.
// Assumes: CYC_PER_US >= 1; us_wrap marks the last cycle of each microsecond,
// so a phase ends exactly N*CYC_PER_US cycles after clear when it is closed on
// (us_wrap && us_cnt == N-1).
module ow_us_timer #(
    parameter int CYC_PER_US = 100,
    parameter int US_W       = 20
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clr,
    output logic [US_W-1:0] us_cnt,
    output logic            us_wrap
);
    localparam int CYC_W = (CYC_PER_US > 1) ? $clog2(CYC_PER_US) : 1;

    logic [CYC_W-1:0] cyc_q;

    assign us_wrap = (cyc_q == CYC_W'(CYC_PER_US - 1));

    // Advance the cycle-in-microsecond and microsecond counters.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cyc_q  <= '0;
            us_cnt <= '0;
        end else if (us_wrap) begin
            cyc_q <= '0;
            if (us_cnt != '1) us_cnt <= us_cnt + 1'b1;
        end else begin
            cyc_q <= cyc_q + 1'b1;
        end
    end

    // R2: each wrap without clear moves the microsecond count by one
    p_us_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (us_wrap && !clr && us_cnt != '1) |=> us_cnt == $past(us_cnt) + 1'b1);
endmodule

// File: rtl/ow_spu_hold.sv
// Strong-pullup hold length: picks SPU_BASE_US * 2^res and flags the last
// cycle of that hold on the shared microsecond timer.
// Assumes: the timer was cleared on the cycle the hold began.
module ow_spu_hold #(
    parameter int SPU_BASE_US = 93750,
    parameter int US_W        = 20
) (
    input  logic [1:0]      res,
    input  logic [US_W-1:0] us_cnt,
    input  logic            us_wrap,
    output logic            hold_end
);
    logic [US_W-1:0] lim [4];

    // One hold limit per resolution step, each twice the previous.
    for (genvar g = 0; g < 4; g++) begin : g_lim
        assign lim[g] = US_W'(SPU_BASE_US) << g;
    end

    assign hold_end = us_wrap && (us_cnt == lim[res] - 1'b1);
endmodule

// File: rtl/ow_master.sv
// Single-wire bus master: runs reset/presence, write slots, read slots and a
// resolution-dependent strong-pullup hold, one command at a time.
// Assumes: line_in is synchronised to clk; CLK_HZ is a whole multiple of
// 1 MHz; all T_*_US timings keep their ordering (low < sample < slot).
module ow_master #(
    parameter int CLK_HZ      = 100_000_000,
    parameter int T_RSTL_US   = 490,
    parameter int T_RSTH_US   = 490,
    parameter int T_PDS_US    = 70,
    parameter int T_SLOT_US   = 70,
    parameter int T_LOW0_US   = 64,
    parameter int T_LOW1_US   = 6,
    parameter int T_RDLOW_US  = 2,
    parameter int T_RDS_US    = 12,
    parameter int T_REC_US    = 2,
    parameter int SPU_BASE_US = 93750
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cmd_valid,
    input  logic [1:0] cmd_op,
    input  logic       cmd_bit,
    input  logic [1:0] cmd_res,
    input  logic       line_in,
    output logic       busy,
    output logic       done,
    output logic       presence,
    output logic       rd_bit,
    output logic       ow_drive_low,
    output logic       spu_en
);
    import ow_pkg::*;

    localparam int CYC_PER_US = CLK_HZ / 1_000_000;
    localparam int SPU_MAX_US = SPU_BASE_US * 8;
    localparam int RST_MAX_US = (T_RSTL_US > T_RSTH_US) ? T_RSTL_US : T_RSTH_US;
    localparam int US_MAX     = ((SPU_MAX_US > RST_MAX_US) ? SPU_MAX_US : RST_MAX_US) + 1;
    localparam int US_W       = $clog2(US_MAX + 1);
    localparam int LOW_LIMIT  = 960 * CYC_PER_US;
    localparam int LRUN_W     = $clog2(LOW_LIMIT + 2);

    ow_state_e       state_q;
    ow_op_e          op_q;
    logic            bit_q;
    logic [1:0]      res_q;
    logic [US_W-1:0] us_cnt;
    logic            us_wrap;
    logic            spu_end;
    logic            phase_end;
    logic            cmd_acc;
    logic [US_W-1:0] low_us;

    // Is the phase timer on the last cycle of microsecond n-1?
    function automatic logic at_us(input logic [US_W-1:0] cnt, input logic wrap, input int n);
        return wrap && (cnt == US_W'(n - 1));
    endfunction

    ow_us_timer #(.CYC_PER_US(CYC_PER_US), .US_W(US_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .clr(cmd_acc || phase_end),
        .us_cnt(us_cnt), .us_wrap(us_wrap)
    );

    ow_spu_hold #(.SPU_BASE_US(SPU_BASE_US), .US_W(US_W)) u_spu (
        .res(res_q), .us_cnt(us_cnt), .us_wrap(us_wrap), .hold_end(spu_end)
    );

    assign cmd_acc = cmd_valid && (state_q == ST_IDLE);
    assign busy    = (state_q != ST_IDLE);
    assign spu_en  = (state_q == ST_PULLUP);

    // Low length of the current slot, chosen by the latched command.
    always_comb begin
        if (op_q == OP_READ) low_us = US_W'(T_RDLOW_US);
        else if (bit_q)      low_us = US_W'(T_LOW1_US);
        else                 low_us = US_W'(T_LOW0_US);
    end

    // Open-drain drive: low during the reset pulse and the slot's low part.
    assign ow_drive_low = (state_q == ST_RST_LOW) ||
                          ((state_q == ST_SLOT) && (us_cnt < low_us));

    // Flag the last cycle of whichever timed phase is running.
    always_comb begin
        case (state_q)
            ST_RST_LOW:  phase_end = at_us(us_cnt, us_wrap, T_RSTL_US);
            ST_RST_HIGH: phase_end = at_us(us_cnt, us_wrap, T_RSTH_US);
            ST_SLOT:     phase_end = at_us(us_cnt, us_wrap, T_SLOT_US);
            ST_RECOVER:  phase_end = at_us(us_cnt, us_wrap, T_REC_US);
            ST_PULLUP:   phase_end = spu_end;
            default:     phase_end = 1'b0;
        endcase
    end

    // Command sequencer: accept, step through phases, sample, signal done.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            op_q     <= OP_RESET;
            bit_q    <= 1'b0;
            res_q    <= 2'd0;
            done     <= 1'b0;
            presence <= 1'b0;
            rd_bit   <= 1'b0;
        end else begin
            done <= 1'b0;
            case (state_q)
                ST_IDLE: if (cmd_acc) begin
                    op_q  <= ow_op_e'(cmd_op);
                    bit_q <= cmd_bit;
                    res_q <= cmd_res;
                    case (ow_op_e'(cmd_op))
                        OP_RESET: begin
                            state_q  <= ST_RST_LOW;
                            presence <= 1'b0;
                        end
                        OP_PULLUP: state_q <= ST_PULLUP;
                        default:   state_q <= ST_SLOT;
                    endcase
                end
                ST_RST_LOW: if (phase_end) state_q <= ST_RST_HIGH;
                ST_RST_HIGH: begin
                    if (at_us(us_cnt, us_wrap, T_PDS_US)) presence <= !line_in;
                    if (phase_end) begin
                        state_q <= ST_IDLE;
                        done    <= 1'b1;
                    end
                end
                ST_SLOT: begin
                    if (op_q == OP_READ && at_us(us_cnt, us_wrap, T_RDS_US)) rd_bit <= line_in;
                    if (phase_end) state_q <= ST_RECOVER;
                end
                ST_RECOVER, ST_PULLUP: if (phase_end) begin
                    state_q <= ST_IDLE;
                    done    <= 1'b1;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Checker-only count of consecutive low cycles on the line.
    logic [LRUN_W-1:0] low_run_q;
    always_ff @(posedge clk) begin
        if (!rst_n || !ow_drive_low) low_run_q <= '0;
        else if (low_run_q != '1)    low_run_q <= low_run_q + 1'b1;
    end

    p_low_limit_r2: assert property (@(posedge clk) disable iff (!rst_n)
        low_run_q < LRUN_W'(LOW_LIMIT));
    p_presence_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_acc && cmd_op == 2'b00) |=> !presence);
    p_spu_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_acc && cmd_op == 2'b11) |=> spu_en);
    p_spu_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
        spu_en |-> !ow_drive_low);
    p_ignore_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cmd_valid) |=> ($stable(op_q) && $stable(bit_q) && $stable(res_q)));
    p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    p_done_on_fall_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);
endmodule

// File: tb/ow_master_tb.sv
// Bench: behavioural slave, cycle-by-cycle reference model, directed checks.
module ow_master_tb_top;
    localparam int CLK_HZ = 2_000_000;
    localparam int CPU    = CLK_HZ / 1_000_000;
    localparam int RSTL = 490, RSTH = 490, PDS = 70, SLOT = 70;
    localparam int LOW0 = 64, LOW1 = 6, RDLOW = 2, RDS = 12, REC = 2;
    localparam int SPUB = 40;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cmd_valid = 1'b0;
    logic [1:0] cmd_op = 2'b00;
    logic cmd_bit = 1'b0;
    logic [1:0] cmd_res = 2'd0;
    logic line_in;
    logic busy, done, presence, rd_bit, ow_drive_low, spu_en;
    logic slave_low = 1'b0;

    int compared = 0;
    int mismatched = 0;

    always #5 clk = ~clk;
    assign line_in = !(ow_drive_low || slave_low);

    ow_master #(
        .CLK_HZ(CLK_HZ), .T_RSTL_US(RSTL), .T_RSTH_US(RSTH), .T_PDS_US(PDS),
        .T_SLOT_US(SLOT), .T_LOW0_US(LOW0), .T_LOW1_US(LOW1), .T_RDLOW_US(RDLOW),
        .T_RDS_US(RDS), .T_REC_US(REC), .SPU_BASE_US(SPUB)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_bit(cmd_bit), .cmd_res(cmd_res), .line_in(line_in), .busy(busy),
        .done(done), .presence(presence), .rd_bit(rd_bit),
        .ow_drive_low(ow_drive_low), .spu_en(spu_en)
    );

    // Behavioural slave: presence after long lows, zero bits on armed reads.
    logic slave_present = 1'b1;
    logic rd_arm = 1'b0;
    logic rd_val = 1'b1;
    int   lrun = 0, pres_wait = 0, hold = 0;
    logic prev_drv = 1'b0;
    always @(negedge clk) begin
        if (ow_drive_low) lrun++;
        else begin
            if (lrun >= 400 * CPU && slave_present) pres_wait = 20 * CPU;
            lrun = 0;
        end
        if (pres_wait > 0) begin
            pres_wait--;
            if (pres_wait == 0) hold = 100 * CPU;
        end
        if (ow_drive_low && !prev_drv && rd_arm && !rd_val) hold = 30 * CPU;
        prev_drv = ow_drive_low;
        if (hold > 0) begin
            slave_low = 1'b1;
            hold--;
        end else slave_low = 1'b0;
    end

    // Reference model, advanced on every rising edge from bench-visible inputs.
    int m_state = 0, m_cnt = 0, m_op = 0, m_bit = 0, m_res = 0;
    logic m_pres = 0, m_rd = 0, m_done = 0;
    function automatic int low_len(input int op, input int b);
        if (op == 2) return RDLOW * CPU;
        return (b != 0) ? LOW1 * CPU : LOW0 * CPU;
    endfunction
    always @(posedge clk) begin
        if (!rst_n) begin
            m_state = 0; m_cnt = 0; m_pres = 0; m_rd = 0; m_done = 0;
        end else begin
            m_done = 0;
            case (m_state)
                0: if (cmd_valid) begin
                    m_op = cmd_op; m_bit = cmd_bit; m_res = cmd_res; m_cnt = 0;
                    if (m_op == 0) begin m_state = 1; m_pres = 0; end
                    else if (m_op == 3) m_state = 5;
                    else m_state = 3;
                end
                1: if (m_cnt == RSTL * CPU - 1) begin m_state = 2; m_cnt = 0; end else m_cnt++;
                2: begin
                    if (m_cnt == PDS * CPU - 1) m_pres = !line_in;
                    if (m_cnt == RSTH * CPU - 1) begin m_state = 0; m_done = 1; end else m_cnt++;
                end
                3: begin
                    if (m_op == 2 && m_cnt == RDS * CPU - 1) m_rd = line_in;
                    if (m_cnt == SLOT * CPU - 1) begin m_state = 4; m_cnt = 0; end else m_cnt++;
                end
                4: if (m_cnt == REC * CPU - 1) begin m_state = 0; m_done = 1; end else m_cnt++;
                5: if (m_cnt == (SPUB << m_res) * CPU - 1) begin m_state = 0; m_done = 1; end else m_cnt++;
                default: m_state = 0;
            endcase
        end
    end

    task automatic check(input string req, input string what, input int act, input int exp);
        compared++;
        if (act != exp) begin
            mismatched++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
        end
    endtask

    // Compare every output with the model away from the active edge.
    always @(negedge clk) if (rst_n) begin
        check("R10", "busy", busy, m_state != 0);
        check("R10", "done", done, m_done);
        check("R2",  "drive_low", ow_drive_low,
              (m_state == 1) || (m_state == 3 && m_cnt < low_len(m_op, m_bit)));
        check("R8",  "spu_en", spu_en, m_state == 5);
        check("R3",  "presence", presence, m_pres);
        check("R6",  "rd_bit", rd_bit, m_rd);
    end

    int busy_c, low_c, spu_c, done_c, spu_first;

    // Issue one command and count busy, low, pullup and done cycles until done.
    task automatic run_cmd(input logic [1:0] op, input logic b, input logic [1:0] r,
                           input int poke_cycles);
        int n = 0;
        busy_c = 0; low_c = 0; spu_c = 0; done_c = 0; spu_first = -1;
        @(negedge clk);
        cmd_op = op; cmd_bit = b; cmd_res = r; cmd_valid = 1'b1;
        while (n < 20000) begin
            @(negedge clk);
            n++;
            if (busy) busy_c++;
            if (ow_drive_low) low_c++;
            if (spu_en) begin spu_c++; if (spu_first < 0) spu_first = n; end
            if (done) begin done_c++; break; end
            if (n == 1) begin
                cmd_op = ~op; cmd_bit = ~b; cmd_res = ~r;
            end
            if (n >= poke_cycles) cmd_valid = 1'b0;
        end
        cmd_valid = 1'b0;
        repeat (3) begin
            @(negedge clk);
            if (done) done_c++;
            check("R9", "busy after done", busy, 0);
        end
    endtask

    initial begin
        repeat (4) @(negedge clk);
        check("R1", "busy", busy, 0);
        check("R1", "done", done, 0);
        check("R1", "drive_low", ow_drive_low, 0);
        check("R1", "spu_en", spu_en, 0);
        check("R1", "presence", presence, 0);
        check("R1", "rd_bit", rd_bit, 0);
        rst_n = 1'b1;

        run_cmd(2'b00, 1'b0, 2'd0, 1);
        check("R2", "reset low cycles", low_c, RSTL * CPU);
        check("R2", "reset busy cycles", busy_c, (RSTL + RSTH) * CPU);
        check("R3", "presence with slave", presence, 1);
        check("R10", "done count", done_c, 1);

        slave_present = 1'b0;
        run_cmd(2'b00, 1'b0, 2'd0, 1);
        check("R3", "presence without slave", presence, 0);
        slave_present = 1'b1;

        run_cmd(2'b01, 1'b0, 2'd0, 1);
        check("R4", "write0 low cycles", low_c, LOW0 * CPU);
        check("R7", "write0 busy cycles", busy_c, (SLOT + REC) * CPU);

        run_cmd(2'b01, 1'b1, 2'd0, 1);
        check("R5", "write1 low cycles", low_c, LOW1 * CPU);
        check("R7", "write1 busy cycles", busy_c, (SLOT + REC) * CPU);

        rd_arm = 1'b1; rd_val = 1'b0;
        run_cmd(2'b10, 1'b0, 2'd0, 1);
        check("R6", "read zero", rd_bit, 0);
        check("R6", "read low cycles (master only)", ow_drive_low, 0);
        rd_val = 1'b1;
        run_cmd(2'b10, 1'b0, 2'd0, 1);
        check("R6", "read one", rd_bit, 1);
        check("R6", "read master low cycles", low_c, RDLOW * CPU);
        rd_arm = 1'b0;

        for (int r = 0; r < 4; r++) begin
            run_cmd(2'b11, 1'b0, 2'(r), 1);
            check("R8", "pullup hold cycles", spu_c, (SPUB << r) * CPU);
            check("R8", "pullup start delay", (spu_first >= 1 && spu_first <= 10 * CPU) ? 1 : 0, 1);
            check("R8", "line low during pullup", low_c, 0);
            check("R10", "pullup done count", done_c, 1);
        end

        run_cmd(2'b01, 1'b1, 2'd0, 40);
        check("R9", "write1 low with pokes", low_c, LOW1 * CPU);
        check("R9", "write1 busy with pokes", busy_c, (SLOT + REC) * CPU);
        check("R10", "single done with pokes", done_c, 1);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check and still summarises.
    initial begin
        repeat (150000) @(posedge clk);
        mismatched++;
        $display("FAIL watchdog expired, actual=hung expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule